// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This unit watches the eight input pins of a general-purpose I/O port and turns pin activity into one interrupt request. Each pin has its own choice of trigger: a level (high or low) or an edge, and for edges either one selected direction or any change. Detected events are held in a sticky raw status register. A per-pin mask gates the raw status onto a single interrupt line, and software clears the status by writing ones to a clear location.

The pin values come in asynchronously and pass through a two-stage synchronizer. The direction vector comes from the port's own data/direction logic, which is outside this unit. Configuration and status sit on a simple single-cycle register bus. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is driven combinationally while `bus_sel` is high and `bus_wr` is low.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every configuration register and the raw status read 0, and `irq` is low.
- R2: The registers at 0x404 (per-pin trigger kind, 1 = level, 0 = edge), 0x408 (per-pin any-edge enable), 0x40C (per-pin polarity) and 0x410 (per-pin mask) read back the last value written. Reads of any unmapped offset return 0.
- R3: A pin in edge mode with any-edge off sets its status bit when its synchronized value changes to the value of its polarity bit (1 = rising, 0 = falling). The opposite edge sets nothing.
- R4: A pin in edge mode with any-edge on sets its status bit on every change, whatever its polarity bit is.
- R5: Edge detection applies only to pins whose `pin_dir` bit is 0 (input). A change on a pin with `pin_dir` = 1 sets no status bit in edge mode.
- R6: A pin in level mode has its status bit set in every cycle in which its synchronized value equals its polarity bit, regardless of direction. The bit therefore reads 1 again right after a clear while the level persists.
- R7: Offset 0x414 reads the raw status, and offset 0x418 reads the raw status ANDed with the mask.
- R8: A write to 0x41C clears each raw status bit whose written bit is 1 and leaves the others unchanged. Writes to 0x414 and 0x418 have no effect.
- R9: `irq` is high exactly when the raw status ANDed with the mask is nonzero.
- R10: A pin change that meets a trigger condition appears in the raw status on the third rising clock edge after it is applied, and not before.
- R11: When a clear and a new event hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 8 | Asynchronous pin values |
| pin_dir | input | 8 | Pin direction, 1 = output, 0 = input |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The bench sweeps every uniform combination of trigger kind, any-edge and polarity, plus one mixed per-pin setting, each with all pins as inputs and with half of them as outputs. Over a sequence of pin patterns it compares raw status, masked status and `irq` against an arithmetic model. A design that ignored polarity, missed the output-pin gating or latched level bits only once would diverge after the first partial clear. Dedicated sequences place a clear in exactly the cycle an edge lands, where a clear-wins design would lose the event. They also count the edges to the first visible status bit, where a missing or extra synchronizer stage shifts it by one cycle.

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W  = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pin_in,
  input  logic [W-1:0]  pin_dir,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq
);

  localparam logic [AW-1:0] A_KIND = AW'(12'h404);
  localparam logic [AW-1:0] A_ANY  = AW'(12'h408);
  localparam logic [AW-1:0] A_POL  = AW'(12'h40C);
  localparam logic [AW-1:0] A_MSK  = AW'(12'h410);
  localparam logic [AW-1:0] A_RAW  = AW'(12'h414);
  localparam logic [AW-1:0] A_MIS  = AW'(12'h418);
  localparam logic [AW-1:0] A_CLR  = AW'(12'h41C);

  logic [W-1:0] sync1_q, sync2_q, last_q;
  logic [W-1:0] lvl_q, any_q, pol_q, msk_q, raw_q;
  logic [W-1:0] match, changed, set_vec, clr_vec;
  logic         wr;

  assign wr = bus_sel & bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      last_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      last_q  <= sync2_q;
    end
  end

  assign match   = ~(sync2_q ^ pol_q);
  assign changed = (sync2_q ^ last_q) & ~pin_dir;
  assign set_vec = (~lvl_q & changed & (any_q | match)) | (lvl_q & match);
  assign clr_vec = (wr && bus_addr == A_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      any_q <= '0;
      pol_q <= '0;
      msk_q <= '0;
      raw_q <= '0;
    end else begin
      if (wr && bus_addr == A_KIND) lvl_q <= bus_wdata;
      if (wr && bus_addr == A_ANY)  any_q <= bus_wdata;
      if (wr && bus_addr == A_POL)  pol_q <= bus_wdata;
      if (wr && bus_addr == A_MSK)  msk_q <= bus_wdata;
      raw_q <= (raw_q & ~clr_vec) | set_vec;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_KIND:  bus_rdata = lvl_q;
        A_ANY:   bus_rdata = any_q;
        A_POL:   bus_rdata = pol_q;
        A_MSK:   bus_rdata = msk_q;
        A_RAW:   bus_rdata = raw_q;
        A_MIS:   bus_rdata = raw_q & msk_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(raw_q & msk_q);

endmodule

module gpio_irq_unit_chk #(
  parameter int W  = 8,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  pin_dir,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic          irq,
  input logic [W-1:0]  lvl_q,
  input logic [W-1:0]  pol_q,
  input logic [W-1:0]  sync2_q,
  input logic [W-1:0]  raw_q,
  input logic [W-1:0]  set_vec
);

  localparam logic [AW-1:0] C_CLR = AW'(12'h41C);
  localparam logic [AW-1:0] C_MIS = AW'(12'h418);

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (raw_q == '0 && !irq));

  assert_no_output_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((raw_q & ~$past(raw_q) & $past(~lvl_q & pin_dir)) == '0));

  assert_level_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((raw_q & $past(lvl_q & ~(sync2_q ^ pol_q))) == $past(lvl_q & ~(sync2_q ^ pol_q))));

  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == C_CLR) |=> ((raw_q & $past(bus_wdata & ~set_vec)) == '0));

  assert_irq_matches_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == C_MIS) |-> (irq == (bus_rdata != '0)));

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_dir(pin_dir), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .lvl_q(lvl_q), .pol_q(pol_q), .sync2_q(sync2_q), .raw_q(raw_q), .set_vec(set_vec)
);

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0, pin_dir = '0, bus_wdata = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;

  gpio_irq_unit i_gpio_irq_unit (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, lvl, any, pol, dir, cur, prv, rawm, msk, clr, lvlhit;
    logic [7:0] pats [7] = '{8'hFF, 8'h0F, 8'hF0, 8'h3C, 8'hC3, 8'hA5, 8'h00};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    foreach (pats[k]) begin end
    rd(12'h404, v); chk("R1 kind", v, 8'h00);
    rd(12'h408, v); chk("R1 any", v, 8'h00);
    rd(12'h40C, v); chk("R1 pol", v, 8'h00);
    rd(12'h410, v); chk("R1 mask", v, 8'h00);
    rd(12'h414, v); chk("R1 raw", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    // R2 readback
    wr(12'h404, 8'h96); wr(12'h408, 8'h3A); wr(12'h40C, 8'hC5); wr(12'h410, 8'h71);
    rd(12'h404, v); chk("R2 kind", v, 8'h96);
    rd(12'h408, v); chk("R2 any", v, 8'h3A);
    rd(12'h40C, v); chk("R2 pol", v, 8'hC5);
    rd(12'h410, v); chk("R2 mask", v, 8'h71);
    rd(12'h400, v); chk("R2 unmapped 400", v, 8'h00);
    rd(12'h420, v); chk("R2 unmapped 420", v, 8'h00);
    rd(12'h41C, v); chk("R2 clear reads 0", v, 8'h00);
    // R10 latency, edge mode rising on pin1
    wr(12'h404, 8'h00); wr(12'h408, 8'h00); wr(12'h40C, 8'hFF); wr(12'h410, 8'h00);
    wr(12'h41C, 8'hFF);
    pin_in = 8'h02;
    @(posedge clk); @(negedge clk); rd(12'h414, v); chk("R10 edge1", v, 8'h00);
    @(posedge clk); @(negedge clk); rd(12'h414, v); chk("R10 edge2", v, 8'h00);
    @(posedge clk); @(negedge clk); rd(12'h414, v); chk("R10 edge3", v, 8'h02);
    // R8 read-only status
    wr(12'h414, 8'h00); wr(12'h418, 8'h00);
    rd(12'h414, v); chk("R8 raw read-only", v, 8'h02);
    // R11 collision: clear lands in the event cycle
    wr(12'h41C, 8'hFF);
    pin_in = 8'h03;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h41C; bus_wdata = 8'h01;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(12'h414, v); chk("R11 set wins", v, 8'h01);
    wr(12'h41C, 8'h01);
    rd(12'h414, v); chk("R8 clear bit", v, 8'h00);
    pin_in = 8'h00; settle();

    // sweep
    for (int cfg = 0; cfg < 9; cfg++) begin
      for (int ds = 0; ds < 2; ds++) begin
        lvl = (cfg == 8) ? 8'h0F : {8{cfg[2]}};
        any = (cfg == 8) ? 8'h33 : {8{cfg[1]}};
        pol = (cfg == 8) ? 8'h55 : {8{cfg[0]}};
        dir = ds ? 8'hA5 : 8'h00;
        pin_in = 8'h00; cur = 8'h00;
        settle(); settle();
        pin_dir = dir;
        wr(12'h404, lvl); wr(12'h408, any); wr(12'h40C, pol); wr(12'h410, 8'h00);
        wr(12'h41C, 8'hFF);
        rawm = lvl & ~(cur ^ pol);
        rd(12'h414, v); chk("R6 after clear", v, rawm);
        foreach (pats[k]) begin
          prv = cur; cur = pats[k];
          pin_in = cur;
          settle();
          lvlhit = lvl & ~(cur ^ pol);
          rawm = rawm | lvlhit | (~lvl & (prv ^ cur) & ~dir & (any | ~(cur ^ pol)));
          rd(12'h414, v); chk("R3 R4 R5 R6 raw", v, rawm);
          msk = cur ^ 8'h5A;
          wr(12'h410, msk);
          rd(12'h418, v); chk("R7 masked", v, rawm & msk);
          chk("R9 irq", {7'd0, irq}, {7'd0, |(rawm & msk)});
          clr = ~cur ^ 8'h18;
          wr(12'h41C, clr);
          rawm = (rawm & ~clr) | lvlhit;
          rd(12'h414, v); chk("R8 partial clear", v, rawm);
        end
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule